// File: doc/BRIEF.md
# Bitonic Memory Sorter

This block sorts a fixed-size set of unsigned keys that it holds in two internal banks. The set size is a power of two, 2^LOG_N. Software-side logic first fills the active bank through a write port while the engine is idle. It then raises `start` for one cycle, waits for the one-cycle `done` pulse, and reads the keys back in ascending order through a read port.

The engine runs a modified bitonic network. It has LOG_N stages, and stage s holds s steps. The first step of a stage pairs each key with its mirror position inside an aligned block of 2^s keys. Every later step pairs keys at a fixed distance that halves on each step, and it never reverses direction. Each clock processes one compare-exchange pair: it reads both keys from the source bank and writes the smaller one to the lower index of the destination bank and the larger one to the higher index. After every step the two banks trade roles.

In merge mode, selected by `merge_only` together with `start`, the engine runs only the last stage. This combines two halves that are each already ascending into one ascending set.

Top module: `bsort_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0.
- R2: After a full sort, reading addresses 0 to N-1 returns the loaded keys in ascending unsigned order.
- R3: A full sort keeps `busy` high for LOG_N*(LOG_N+1)/2 * N/2 cycles after the edge that accepts `start`. `done` is 1 for exactly one cycle, which is the first cycle with `busy` low again.
- R4: With `merge_only`=1 at start, `busy` stays high for LOG_N * N/2 cycles. If addresses 0..N/2-1 and N/2..N-1 each hold ascending keys, the result is fully ascending.
- R5: A `start` raised while `busy` is 1 is ignored. The run in progress keeps its mode and its length.
- R6: A `start` raised in the cycle where `done` is 1 is accepted, and `busy` is 1 in the following cycle.
- R7: A write through the load port while `busy` is 1 has no effect on the sorted result.
- R8: Equal keys, the key 0 and the all-ones key sort correctly.
- R9: While idle, a key written at an address reads back unchanged at that address.
- R10: Each compare-exchange pairs a lower index with a higher index. The smaller key goes to the lower index, and the stage and step counters stay within 1 <= step <= stage <= LOG_N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| merge_only | input | 1 | Sampled with start: 1 runs only the final stage |
| wr_en | input | 1 | Load-port write enable, honoured only while idle |
| wr_addr | input | LOG_N | Load-port address |
| wr_data | input | DATA_W | Load-port key |
| rd_addr | input | LOG_N | Unload-port address |
| rd_data | output | DATA_W | Key at rd_addr in the active bank |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |

## Verification
The end of a run and the acceptance of a new request can land in the same cycle. In the cycle where `done` pulses, the bench raises `start` and expects `busy` to be high in the next cycle. In a separate case it raises `start` with merge mode during a running sort and expects that request to be dropped. A reference model in the bench counts the expected run length from the mode. It predicts `busy` and `done` for every clock, so an early restart or a lost request shows up as a mismatch in the exact cycle where it happens. The final contents are then compared with a sorted copy of the loaded keys.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    // Run mode latched when a start request is accepted
    typedef enum logic {
        MODE_FULL  = 1'b0,
        MODE_MERGE = 1'b1
    } sort_mode_e;

    // How the partner of a lower index is formed in the current step
    typedef enum logic {
        PAIR_MIRROR = 1'b0,
        PAIR_STRIDE = 1'b1
    } pair_kind_e;

endpackage

// File: rtl/bsort_ctrl.sv
module bsort_ctrl
    import bsort_pkg::*;
#(
    parameter int LOG_N = 6,
    parameter int SW    = $clog2(LOG_N + 1),
    parameter int PW    = LOG_N - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          merge_only,
    output logic          busy,
    output logic          done,
    output logic          cur_bank,
    output logic [SW-1:0] stage,
    output logic [SW-1:0] step,
    output logic [PW-1:0] pair,
    output pair_kind_e    kind,
    output sort_mode_e    mode
);

    localparam logic [SW-1:0] STAGE_LAST = SW'(LOG_N);
    localparam logic [SW-1:0] STAGE_ONE  = SW'(1);
    localparam logic [PW-1:0] PAIR_LAST  = {PW{1'b1}};

    typedef struct packed {
        logic          busy;
        logic          done;
        sort_mode_e    mode;
        logic          cur;
        logic [SW-1:0] stage;
        logic [SW-1:0] step;
        logic [PW-1:0] pair;
    } ctrl_s;

    ctrl_s st_d, st_q;

    logic end_of_step;
    logic end_of_stage;
    logic end_of_run;

    always_comb begin
        end_of_step  = (st_q.pair == PAIR_LAST);
        end_of_stage = end_of_step && (st_q.step == STAGE_ONE);
        end_of_run   = end_of_stage && (st_q.stage == STAGE_LAST);

        st_d      = st_q;
        st_d.done = 1'b0;

        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.mode  = merge_only ? MODE_MERGE : MODE_FULL;
                st_d.stage = merge_only ? STAGE_LAST : STAGE_ONE;
                st_d.step  = merge_only ? STAGE_LAST : STAGE_ONE;
                st_d.pair  = '0;
            end
        end else begin
            st_d.pair = st_q.pair + PW'(1);
            if (end_of_step) begin
                st_d.cur = ~st_q.cur;
                if (end_of_run) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end else if (end_of_stage) begin
                    st_d.stage = st_q.stage + SW'(1);
                    st_d.step  = st_q.stage + SW'(1);
                end else begin
                    st_d.step = st_q.step - SW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.done  <= 1'b0;
            st_q.mode  <= MODE_FULL;
            st_q.cur   <= 1'b0;
            st_q.stage <= STAGE_ONE;
            st_q.step  <= STAGE_ONE;
            st_q.pair  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign cur_bank = st_q.cur;
    assign stage    = st_q.stage;
    assign step     = st_q.step;
    assign pair     = st_q.pair;
    assign mode     = st_q.mode;
    assign kind     = (st_q.step == st_q.stage) ? PAIR_MIRROR : PAIR_STRIDE;

    // R3: completion pulse lasts one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: every fall of busy is marked by done
    a_r3_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R1: done only while idle
    a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: a running sequence advances one pair per clock whatever start does
    a_r5_pair_advances: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> pair == $past(pair) + PW'(1));

    // R5: a request while busy leaves the mode untouched
    a_r5_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> mode == $past(mode));

    // R10: counters remain in range
    a_r10_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step >= STAGE_ONE) && (step <= stage) && (stage <= STAGE_LAST));

    // R4: merge runs never leave the last stage
    a_r4_merge_last_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == MODE_MERGE) |-> stage == STAGE_LAST);

endmodule

// File: rtl/bsort_pair.sv
module bsort_pair
    import bsort_pkg::*;
#(
    parameter int LOG_N = 6,
    parameter int SW    = $clog2(LOG_N + 1),
    parameter int PW    = LOG_N - 1
) (
    input  pair_kind_e       kind,
    input  logic [SW-1:0]    stage,
    input  logic [SW-1:0]    step,
    input  logic [PW-1:0]    pair,
    output logic [LOG_N-1:0] lo_idx,
    output logic [LOG_N-1:0] hi_idx
);

    logic [LOG_N-1:0] pair_w;
    logic [SW-1:0]    gap_sh;
    logic [LOG_N-1:0] gap;
    logic [LOG_N-1:0] below_mask;
    logic [LOG_N-1:0] block_mask;

    always_comb begin
        pair_w     = {1'b0, pair};
        gap_sh     = step - SW'(1);
        gap        = LOG_N'(1) << gap_sh;
        below_mask = gap - LOG_N'(1);
        // stage == LOG_N wraps to all ones, covering the whole set
        block_mask = (LOG_N'(1) << stage) - LOG_N'(1);

        // open a zero bit at the gap position: the lower member of the pair
        lo_idx = ((pair_w & ~below_mask) << 1) | (pair_w & below_mask);

        if (kind == PAIR_MIRROR) begin
            hi_idx = lo_idx ^ block_mask;
        end else begin
            hi_idx = lo_idx | gap;
        end
    end

endmodule

// File: rtl/bsort_cmpx.sv
module bsort_cmpx #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] key_a,
    input  logic [DATA_W-1:0] key_b,
    output logic [DATA_W-1:0] key_min,
    output logic [DATA_W-1:0] key_max
);

    logic swap;

    always_comb begin
        swap    = key_a > key_b;
        key_min = swap ? key_b : key_a;
        key_max = swap ? key_a : key_b;
    end

endmodule

// File: rtl/bsort_store.sv
module bsort_store #(
    parameter int DATA_W = 32,
    parameter int LOG_N  = 6,
    parameter int N      = 1 << LOG_N
) (
    input  logic              clk,
    input  logic              src_sel,
    input  logic              sort_we,
    input  logic [LOG_N-1:0]  lo_idx,
    input  logic [LOG_N-1:0]  hi_idx,
    input  logic [DATA_W-1:0] put_min,
    input  logic [DATA_W-1:0] put_max,
    input  logic              load_we,
    input  logic [LOG_N-1:0]  load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [LOG_N-1:0]  rd_addr,
    output logic [DATA_W-1:0] src_lo,
    output logic [DATA_W-1:0] src_hi,
    output logic [DATA_W-1:0] rd_data
);

    logic [1:0][DATA_W-1:0] lo_v;
    logic [1:0][DATA_W-1:0] hi_v;
    logic [1:0][DATA_W-1:0] rd_v;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DATA_W-1:0] mem [N];
        logic              is_src;

        assign is_src = (src_sel == 1'(b));

        always_ff @(posedge clk) begin
            if (sort_we && !is_src) begin
                mem[lo_idx] <= put_min;
                mem[hi_idx] <= put_max;
            end else if (load_we && is_src) begin
                mem[load_addr] <= load_data;
            end
        end

        assign lo_v[b] = mem[lo_idx];
        assign hi_v[b] = mem[hi_idx];
        assign rd_v[b] = mem[rd_addr];
    end

    assign src_lo  = lo_v[src_sel];
    assign src_hi  = hi_v[src_sel];
    assign rd_data = rd_v[src_sel];

endmodule

// File: rtl/bsort_engine.sv
module bsort_engine
    import bsort_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LOG_N  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              merge_only,
    input  logic              wr_en,
    input  logic [LOG_N-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LOG_N-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);

    localparam int N  = 1 << LOG_N;
    localparam int SW = $clog2(LOG_N + 1);
    localparam int PW = LOG_N - 1;

    logic              cur_bank;
    logic [SW-1:0]     stage;
    logic [SW-1:0]     step;
    logic [PW-1:0]     pair;
    pair_kind_e        kind;
    sort_mode_e        mode;
    logic [LOG_N-1:0]  lo_idx;
    logic [LOG_N-1:0]  hi_idx;
    logic [DATA_W-1:0] src_lo;
    logic [DATA_W-1:0] src_hi;
    logic [DATA_W-1:0] key_min;
    logic [DATA_W-1:0] key_max;
    logic              load_we;

    assign load_we = wr_en && !busy;

    bsort_ctrl #(.LOG_N(LOG_N), .SW(SW), .PW(PW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .merge_only (merge_only),
        .busy       (busy),
        .done       (done),
        .cur_bank   (cur_bank),
        .stage      (stage),
        .step       (step),
        .pair       (pair),
        .kind       (kind),
        .mode       (mode)
    );

    bsort_pair #(.LOG_N(LOG_N), .SW(SW), .PW(PW)) u_pair (
        .kind   (kind),
        .stage  (stage),
        .step   (step),
        .pair   (pair),
        .lo_idx (lo_idx),
        .hi_idx (hi_idx)
    );

    bsort_cmpx #(.DATA_W(DATA_W)) u_cmpx (
        .key_a   (src_lo),
        .key_b   (src_hi),
        .key_min (key_min),
        .key_max (key_max)
    );

    bsort_store #(.DATA_W(DATA_W), .LOG_N(LOG_N), .N(N)) u_store (
        .clk       (clk),
        .src_sel   (cur_bank),
        .sort_we   (busy),
        .lo_idx    (lo_idx),
        .hi_idx    (hi_idx),
        .put_min   (key_min),
        .put_max   (key_max),
        .load_we   (load_we),
        .load_addr (wr_addr),
        .load_data (wr_data),
        .rd_addr   (rd_addr),
        .src_lo    (src_lo),
        .src_hi    (src_hi),
        .rd_data   (rd_data)
    );

    // R10: the pair generator always yields a lower and a distinct higher index
    a_r10_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> lo_idx < hi_idx);

    // R10: the value bound for the lower index never exceeds the higher one
    a_r10_min_at_low: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> key_min <= key_max);

    // R3: the bank selector flips only when a run is in progress
    a_r3_bank_flip_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bank != $past(cur_bank)) |-> $past(busy));

    // R4: merge mode starts its run in the mirror step of the final stage
    a_r4_merge_first_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && mode == MODE_MERGE) |-> kind == PAIR_MIRROR);

endmodule

// File: tb/bsort_engine_bench.sv
module bsort_engine_bench;

    localparam int CLK_PERIOD  = 10;
    localparam int DATA_W      = 32;
    localparam int LOG_N       = 6;
    localparam int N           = 1 << LOG_N;
    localparam int FULL_PAIRS  = (LOG_N * (LOG_N + 1) / 2) * (N / 2);
    localparam int MERGE_PAIRS = LOG_N * (N / 2);

    typedef logic [DATA_W-1:0] key_t;
    typedef key_t key_q_t [$];

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              merge_only = 1'b0;
    logic              wr_en = 1'b0;
    logic [LOG_N-1:0]  wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [LOG_N-1:0]  rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              busy;
    logic              done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bsort_engine #(.DATA_W(DATA_W), .LOG_N(LOG_N)) u_bsort_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .merge_only (merge_only),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural timing model: run length follows from the mode alone
    bit m_busy = 1'b0;
    bit m_done = 1'b0;
    bit m_merge = 1'b0;
    int m_left = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_done <= 1'b0;
            m_left <= 0;
        end else begin
            m_done <= 1'b0;
            if (m_busy) begin
                if (m_left == 1) begin
                    m_busy <= 1'b0;
                    m_done <= 1'b1;
                end else begin
                    m_left <= m_left - 1;
                end
            end else if (start) begin
                m_busy  <= 1'b1;
                m_merge <= merge_only;
                m_left  <= merge_only ? MERGE_PAIRS : FULL_PAIRS;
            end
        end
    end

    // Compare status against the model on every falling edge (R3, R4, R5, R6)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy == m_busy, m_merge ? "R4" : "R3", "busy per cycle", busy, m_busy);
            check(done == m_done, m_merge ? "R4" : "R3", "done per cycle", done, m_done);
        end
    end

    task automatic load_keys(input key_q_t v);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = LOG_N'(i);
            wr_data = v[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic kick(input bit m);
        @(negedge clk);
        start      = 1'b1;
        merge_only = m;
        @(negedge clk);
        start      = 1'b0;
        merge_only = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) check(1'b0, req, "watchdog waiting for done", 0, 1);
    endtask

    task automatic unload_check(input key_q_t exp, input string req);
        int errs = 0;
        for (int i = 0; i < N; i++) begin
            rd_addr = LOG_N'(i);
            #1;
            if (rd_data !== exp[i]) begin
                errs++;
                if (errs <= 4)
                    check(1'b0, req, $sformatf("key at %0d", i), rd_data, exp[i]);
            end
        end
        if (errs == 0) check(1'b1, req, "ordered unload", 0, 0);
    endtask

    function automatic key_q_t rand_keys(input int n);
        key_q_t q;
        for (int i = 0; i < n; i++) q.push_back($urandom());
        return q;
    endfunction

    function automatic key_q_t sorted(input key_q_t v);
        key_q_t q = v;
        q.sort();
        return q;
    endfunction

    task automatic finish_run();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            check(1'b0, "R3", "global watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        key_q_t keys;
        key_q_t half_a;
        key_q_t half_b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle state after reset
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);

        // R9: idle write then read back at the same address
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd5;  wr_data = 32'hABCD_1234;
        @(negedge clk);
        wr_addr = 6'd63; wr_data = 32'h0000_0001;
        @(negedge clk);
        wr_en = 1'b0;
        rd_addr = 6'd5;  #1;
        check(rd_data == 32'hABCD_1234, "R9", "readback addr 5", rd_data, 32'hABCD_1234);
        rd_addr = 6'd63; #1;
        check(rd_data == 32'h1, "R9", "readback addr 63", rd_data, 1);

        // R2 and R3: full sort of random keys
        keys = rand_keys(N);
        load_keys(keys);
        kick(1'b0);
        wait_done("R3");
        @(negedge clk);
        check(done == 1'b0, "R3", "done lasts one cycle", done, 0);
        unload_check(sorted(keys), "R2");

        // R8: duplicates, zero and all-ones, descending start
        keys = {};
        for (int i = 0; i < N; i++) begin
            if (i % 9 == 0)      keys.push_back(32'hFFFF_FFFF);
            else if (i % 7 == 0) keys.push_back(32'h0);
            else                 keys.push_back(key_t'((N - i) % 5));
        end
        load_keys(keys);
        kick(1'b0);
        wait_done("R8");
        unload_check(sorted(keys), "R8");

        // R4: merge two ascending halves
        half_a = sorted(rand_keys(N / 2));
        half_b = sorted(rand_keys(N / 2));
        keys = {half_a, half_b};
        load_keys(keys);
        kick(1'b1);
        wait_done("R4");
        unload_check(sorted(keys), "R4");

        // R5: request with merge mode during a full sort must be dropped
        keys = rand_keys(N);
        load_keys(keys);
        kick(1'b0);
        repeat (100) @(negedge clk);
        start = 1'b1; merge_only = 1'b1;
        @(negedge clk);
        start = 1'b0; merge_only = 1'b0;
        check(busy == 1'b1, "R5", "still busy after ignored start", busy, 1);
        wait_done("R5");
        unload_check(sorted(keys), "R5");

        // R7: load-port writes while busy have no effect
        keys = rand_keys(N);
        load_keys(keys);
        kick(1'b0);
        repeat (50) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            wr_en   = 1'b1;
            wr_addr = LOG_N'(i * 5);
            wr_data = 32'hDEAD_0000 + key_t'(i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        wait_done("R7");
        unload_check(sorted(keys), "R7");

        // R6: new request raised in the done cycle is accepted
        keys = rand_keys(N);
        load_keys(keys);
        kick(1'b0);
        wait_done("R6");
        start = 1'b1; merge_only = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R6", "busy after start in done cycle", busy, 1);
        wait_done("R6");
        unload_check(sorted(keys), "R6");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule